// File: doc/BRIEF.md
# Pulse density modulator

This block turns an unsigned N-bit level into a one-bit stream for a single output pin. An external low-pass filter on that pin then yields an analog voltage proportional to the level. The block uses a first-order accumulate-and-carry scheme. On every enabled clock, the held level is added into an N-bit accumulator, and the carry out of that addition becomes the next output bit.

A high output therefore lasts exactly one clock whenever the level is at or below half scale. The level is set by how far apart the high cycles are. Over each run of 2^N cycles, the number of high cycles equals the held level.

The level is captured from the `level_in` bus only when `level_ld` is strobed, so the bus may change freely at other times. Deasserting `run_en` parks the output low and clears the accumulator. The next enabled run therefore starts from a known phase.

Top module: `pdm_dac`

## Requirements
- R1: While `rst_n` is low, `pdm_out` is 0 and both the held level and the accumulator are cleared.
- R2: At a rising edge with `level_ld` high, the held level takes the value of `level_in`. That value governs every output bit computed from the next edge onwards.
- R3: At edges with `level_ld` low, the held level is unchanged, so any activity on `level_in` has no effect on `pdm_out`.
- R4: At each edge with `run_en` high, the accumulator becomes (acc + level) mod 2^N, and `pdm_out` takes the carry of that sum. After the k-th enabled edge of a run that started from a cleared accumulator, `pdm_out` equals floor(k*L/2^N) - floor((k-1)*L/2^N).
- R5: At an edge with `run_en` low, `pdm_out` becomes 0 and the accumulator is cleared. A following run restarts its pattern from k = 1.
- R6: A held level of 0 keeps `pdm_out` low on every cycle.
- R7: A mid-scale level (2^(N-1)) produces low on the first enabled edge and then alternates high and low on every clock.
- R8: With a constant held level L, any 2^N consecutive enabled cycles contain exactly L high cycles.
- R9: For a held level at or below 2^(N-1), a high output cycle is always followed by a low one, so every pulse is one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Modulator enable; low parks the output low and clears the accumulator |
| level_ld | input | 1 | Strobe that captures `level_in` into the held level |
| level_in | input | N (default 8) | Unsigned level to be modulated |
| pdm_out | output | 1 | Registered one-bit density stream |

## Verification
The bench covers the following corner cases, each with the failure it would expose:
- Level 0: a design that emitted a stray carry would show a high cycle.
- Level 1: a wrong carry position would misplace or drop the single pulse at the end of the window.
- Level 255: dropping a carry would lose one pulse in the window.
- Mid-scale: an off-by-one phase would invert the alternating pattern.
- Bus changes without a strobe: a design that tracked `level_in` directly would fail the window counts.
- Disabling mid-run: a design that left the accumulator uncleared would resume with a shifted pattern instead of restarting at k = 1.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // Largest level for an N-bit modulator, i.e. 2^N - 1.
  function automatic int unsigned pdm_top_level(input int unsigned w);
    return (1 << w) - 1;
  endfunction

  // Half scale, 2^(N-1): the highest level that still gives single-cycle pulses.
  function automatic int unsigned pdm_half_level(input int unsigned w);
    return 1 << (w - 1);
  endfunction

endpackage

// File: rtl/pdm_level_reg.sv
module pdm_level_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld) begin
      q <= din;
    end
  end

endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] inc,
  output logic         carry_w,
  output logic         bit_q
);

  logic [W-1:0] acc_q;
  logic [W:0]   step;

  // Extend both operands by one bit; the extra bit of the sum is the carry.
  function automatic logic [W:0] acc_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign step    = acc_add(acc_q, inc);
  assign carry_w = step[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (!en) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else begin
      acc_q <= step[W-1:0];
      bit_q <= carry_w;
    end
  end

endmodule

// File: rtl/pdm_dac.sv
module pdm_dac #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         level_ld,
  input  logic [W-1:0] level_in,
  output logic         pdm_out
);

  logic [W-1:0] held_q;
  logic         carry_w;

  pdm_level_reg #(.W(W)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (level_ld),
    .din   (level_in),
    .q     (held_q)
  );

  pdm_accum #(.W(W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_en),
    .inc     (held_q),
    .carry_w (carry_w),
    .bit_q   (pdm_out)
  );

endmodule

// File: rtl/pdm_dac_chk.sv
module pdm_dac_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         level_ld,
  input logic [W-1:0] level_in,
  input logic         pdm_out,
  input logic [W-1:0] held_q
);

  localparam int unsigned HALF = pdm_pkg::pdm_half_level(W);

  // R5
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !pdm_out);

  // R6
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q == '0) |=> !pdm_out);

  // R2
  level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_ld |=> (held_q == $past(level_in)));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !level_ld |=> $stable(held_q));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdm_out && $stable(held_q) && (held_q <= W'(HALF))) |=> !pdm_out);

endmodule

bind pdm_dac pdm_dac_chk #(.W(W)) u_pdm_dac_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .level_ld (level_ld),
  .level_in (level_in),
  .pdm_out  (pdm_out),
  .held_q   (held_q)
);

// File: tb/test_pdm_dac.sv
module test_pdm_dac;

  localparam int W   = 8;
  localparam int WIN = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_en = 1'b0;
  logic         level_ld = 1'b0;
  logic [W-1:0] level_in = '0;
  logic         pdm_out;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   ones  = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  pdm_dac #(.W(W)) i_pdm_dac (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .level_ld (level_ld),
    .level_in (level_in),
    .pdm_out  (pdm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Expected bit k of a run with level v, written as a difference of floor terms.
  function automatic logic model_bit(input int v, input int k);
    return logic'(((k * v) / WIN) - (((k - 1) * v) / WIN));
  endfunction

  // Monitor: pops one expected item per clock, just after the edge.
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (pdm_out) ones++;
      check(pdm_out == e.val, e.tag, int'(pdm_out), int'(e.val));
    end
  end

  task automatic push_run(input int v, input int n, input string tag);
    for (int k = 1; k <= n; k++) begin
      exp_t e;
      e.val = model_bit(v, k);
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // Load v with the modulator parked, then run one full window.
  task automatic run_level(input int v, input string tag);
    @(negedge clk);
    run_en   = 1'b0;
    level_ld = 1'b1;
    level_in = W'(v);
    @(negedge clk);
    level_ld = 1'b0;
    level_in = ~W'(v);  // R3: bus noise without a strobe
    ones = 0;
    push_run(v, WIN, tag);
    run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    // R8: high count over the window equals the level
    check(ones == v, "R8 window count", ones, v);
  endtask

  initial begin
    #3;
    // R1: output low during reset
    check(pdm_out == 1'b0, "R1 reset", int'(pdm_out), 0);
    repeat (3) @(negedge clk);
    check(pdm_out == 1'b0, "R1 reset held", int'(pdm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pdm_out == 1'b0, "R1 after release", int'(pdm_out), 0);

    run_level(0,   "R6 zero level");
    run_level(128, "R7 mid-scale");
    run_level(1,   "R4 level one");
    run_level(255, "R4 full scale");
    run_level(100, "R9 level 100");
    run_level(37,  "R2 level 37");

    // R5: disable mid-run, then the pattern restarts at k = 1
    @(negedge clk);
    run_en   = 1'b0;
    level_ld = 1'b1;
    level_in = 8'd77;
    @(negedge clk);
    level_ld = 1'b0;
    push_run(77, 100, "R5 first part");
    run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    run_en = 1'b0;
    @(posedge clk);
    #2;
    check(pdm_out == 1'b0, "R5 parked low", int'(pdm_out), 0);
    @(negedge clk);
    ones = 0;
    push_run(77, WIN, "R5 restart");
    run_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    check(ones == 77, "R8 window after restart", ones, 77);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule